// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs one dual-slope analog-to-digital conversion and returns the result as packed BCD digits. An external integrator sits between two analog switches. One switch connects the unknown input and the other the negative reference. An external zero-crossing comparator reports whether the integrator output is above zero. The block drives both switches, watches the comparator and counts clock cycles in a single decimal counter.

A start pulse clears the counter and enters the charge phase (`ST_INTEG`) with the input switch closed. The count gate is open only while the synchronized comparator reads 1. The charge phase therefore lasts exactly one full lap of the counter. When the counter wraps from all nines to zero, the block moves to the discharge phase (`ST_DEINT`): the input switch opens and the reference switch closes. The same counter, restarted from zero, then counts until the comparator falls back to 0. That final count is proportional to the input voltage relative to the reference. Clock frequency and integrator time constant cancel out of it.

The FSM has three states. `ST_IDLE` goes to `ST_INTEG` on start. `ST_INTEG` goes to `ST_DEINT` on counter wrap. `ST_DEINT` goes to `ST_IDLE` when the comparator falls or the counter would wrap a second time. A start pulse seen in `ST_INTEG` or `ST_DEINT` sends the FSM back to `ST_INTEG` with a cleared counter.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset, busy, done, over_range, both switch drives and result_bcd are all 0.
- R2: A start pulse sampled at a clock edge clears the counter. From that edge on, sw_sig=1, sw_refn=0 and busy=1.
- R3: cmp_raw passes through a two-stage synchronizer. The counter advances at an edge only if the synchronized value is 1 and a conversion is running, so a change of cmp_raw takes effect two edges later.
- R4: The counter holds DIGITS BCD digits, each 4 bits with the least significant digit in bits [3:0]. A digit moves to the next digit only when it wraps from 9 to 0, and no digit ever holds 10 to 15.
- R5: The charge phase ends at the wrap from all nines to zero, after 10^DIGITS gated counts. At that edge sw_sig falls and sw_refn rises together. With cmp_raw raised and held at 1, this happens 10^DIGITS+2 edges after the first edge that samples it high.
- R6: In the discharge phase the counter counts from zero. The result is the number of discharge edges at which the synchronized comparator was 1. The conversion finishes at the first discharge edge at which it reads 0.
- R7: At the finishing edge, result_bcd and over_range are loaded and done is high for exactly one cycle. busy, sw_sig and sw_refn drop to 0 and stay there until the next start.
- R8: If the discharge count is at all nines and the synchronized comparator is still 1, the conversion finishes as over-range: result_bcd is all nines and over_range=1. Otherwise over_range=0.
- R9: A start pulse during a conversion aborts it and restarts the charge phase without raising done or changing result_bcd.
- R10: result_bcd and over_range hold their values from one done to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start (or restart) pulse, one cycle |
| cmp_raw | input | 1 | Asynchronous zero-crossing comparator output, 1 = integrator above zero |
| sw_sig | output | 1 | Closes the input-voltage switch |
| sw_refn | output | 1 | Closes the negative-reference switch |
| busy | output | 1 | A conversion is running |
| done | output | 1 | One-cycle completion strobe |
| over_range | output | 1 | Last result saturated |
| result_bcd | output | 4*DIGITS | Held BCD result, digit 0 in bits [3:0] |

## Verification
The bench builds the block with DIGITS=2. This shrinks the fixed charge phase to 100 counts, so dozens of full conversions fit in a short run. With DIGITS=2, one run reaches the exact-full-scale count of 99, the first over-range case and long discharges far past full scale, as well as the 9-to-0 digit carry. The synchronizer depth stays at its default of 2, so the two-edge comparator delay in the bench's expected counts is the one the block ships with.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2
    } phase_t;

    localparam int unsigned BCD_W = 4;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], d_async};
        end
    end

    assign q_sync = shreg[STAGES-1];
endmodule

// File: rtl/dsadc_bcd_cnt.sv
module dsadc_bcd_cnt #(
    parameter int unsigned DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    output logic [4*DIGITS-1:0]   cnt_q,
    output logic                  wrap
);
    import dsadc_pkg::*;

    logic [DIGITS:0] carry;

    assign carry[0] = en;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [BCD_W-1:0] dig;
        assign dig = cnt_q[g*BCD_W +: BCD_W];
        assign carry[g+1] = carry[g] && (dig == 4'd9);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g*BCD_W +: BCD_W] <= '0;
            end else if (clr) begin
                cnt_q[g*BCD_W +: BCD_W] <= '0;
            end else if (carry[g]) begin
                cnt_q[g*BCD_W +: BCD_W] <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
            end
        end

        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            dig <= 4'd9); // R4
    end

    assign wrap = carry[DIGITS];

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl #(
    parameter int unsigned DIGITS      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start,
    input  logic                cmp_raw,
    output logic                sw_sig,
    output logic                sw_refn,
    output logic                busy,
    output logic                done,
    output logic                over_range,
    output logic [4*DIGITS-1:0] result_bcd
);
    import dsadc_pkg::*;

    localparam int unsigned W = BCD_W * DIGITS;

    function automatic logic [W-1:0] all_nines();
        logic [W-1:0] v;
        for (int i = 0; i < int'(DIGITS); i++) begin
            v[i*BCD_W +: BCD_W] = 4'd9;
        end
        return v;
    endfunction

    localparam logic [W-1:0] NINES = all_nines();

    phase_t       state_q, state_d;
    logic         cmp_s;
    logic         cnt_en;
    logic         cnt_wrap;
    logic [W-1:0] cnt_q;
    logic         finish;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (cmp_s)
    );

    assign cnt_en = cmp_s && !conv_start && (state_q != ST_IDLE);
    assign finish = (state_q == ST_DEINT) && !conv_start && (cnt_wrap || !cmp_s);

    dsadc_bcd_cnt #(.DIGITS(DIGITS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (conv_start),
        .en    (cnt_en),
        .cnt_q (cnt_q),
        .wrap  (cnt_wrap)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_start) state_d = ST_INTEG;
            end
            ST_INTEG: begin
                if (conv_start)    state_d = ST_INTEG;
                else if (cnt_wrap) state_d = ST_DEINT;
            end
            ST_DEINT: begin
                if (conv_start)  state_d = ST_INTEG;
                else if (finish) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            over_range <= 1'b0;
            result_bcd <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                over_range <= cnt_wrap;
                result_bcd <= cnt_wrap ? NINES : cnt_q;
            end
        end
    end

    assign sw_sig  = (state_q == ST_INTEG);
    assign sw_refn = (state_q == ST_DEINT);
    assign busy    = (state_q != ST_IDLE);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (cnt_q == '0 && sw_sig && !sw_refn)); // R2
    AST_PHASE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_refn) |-> (cnt_q == '0)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sw_sig && !sw_refn)); // R7
    AST_OVR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && over_range) |-> (result_bcd == NINES)); // R8
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !done); // R9
endmodule

// File: tb/dsadc_ctrl_tb_top.sv
module dsadc_ctrl_tb_top;
    localparam int DIG = 2;
    localparam int W   = 4 * DIG;
    localparam int MAX = 10 ** DIG - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic cmp_raw = 1'b0;
    logic sw_sig, sw_refn, busy, done, over_range;
    logic [W-1:0] result_bcd;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dsadc_ctrl #(.DIGITS(DIG), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .cmp_raw    (cmp_raw),
        .sw_sig     (sw_sig),
        .sw_refn    (sw_refn),
        .busy       (busy),
        .done       (done),
        .over_range (over_range),
        .result_bcd (result_bcd)
    );

    function automatic logic [W-1:0] to_bcd(int v);
        logic [W-1:0] r;
        int x = v;
        for (int i = 0; i < DIG; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // Discharge counts: cmp held high for h edges, plus two synchronizer edges
    function automatic int exp_count(int h);
        return (h + 2 > MAX) ? MAX : h + 2;
    endfunction

    function automatic int exp_done_edge(int h);
        return (h + 2 > MAX) ? MAX + 1 : h + 3;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic pulse_start();
        conv_start = 1'b1;
        cmp_raw    = 1'b0;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic run_conv(int d0, int h);
        logic [W-1:0] prev_res = result_bcd;
        logic         prev_ovr = over_range;
        int           k;
        pulse_start();
        chk(sw_sig && !sw_refn && busy, "R2", {sw_sig, sw_refn, busy}, 3'b101);
        repeat (d0) @(negedge clk);
        cmp_raw = 1'b1;
        k = 0;
        while (!sw_refn && k < 4 * MAX) begin
            @(negedge clk);
            k++;
            if (k == 10)
                chk(result_bcd == prev_res && over_range == prev_ovr, "R10",
                    int'(result_bcd), int'(prev_res));
        end
        chk(k == MAX + 3, "R5 charge length", k, MAX + 3);
        chk(!sw_sig, "R5 input switch open", int'(sw_sig), 0);
        k = 0;
        while (!done && k < 4 * MAX) begin
            @(negedge clk);
            k++;
            if (k == h) cmp_raw = 1'b0;
        end
        cmp_raw = 1'b0;
        chk(k == exp_done_edge(h), "R6 finish edge", k, exp_done_edge(h));
        chk(result_bcd == to_bcd(exp_count(h)), "R6 R4 result",
            int'(result_bcd), int'(to_bcd(exp_count(h))));
        chk(over_range == (h + 2 > MAX), "R8 over_range", int'(over_range),
            int'(h + 2 > MAX));
        chk(!busy && !sw_sig && !sw_refn, "R7 idle at done",
            {busy, sw_sig, sw_refn}, 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_abort(bit in_discharge);
        logic [W-1:0] prev_res = result_bcd;
        int k = 0;
        pulse_start();
        cmp_raw = 1'b1;
        if (in_discharge) begin
            while (!sw_refn && k < 4 * MAX) begin
                @(negedge clk);
                k++;
            end
        end
        repeat (5) @(negedge clk);
        pulse_start();
        chk(sw_sig && !sw_refn && busy && !done, "R9 restart",
            {sw_sig, sw_refn, busy, done}, 4'b1010);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!done && result_bcd == prev_res, "R9 no done",
                int'(result_bcd), int'(prev_res));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !over_range && !sw_sig && !sw_refn && result_bcd == '0,
            "R1 in reset", int'(result_bcd), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !over_range && !sw_sig && !sw_refn && result_bcd == '0,
            "R1 after reset", {busy, done, over_range, sw_sig, sw_refn}, 0);
        // R3: the delay d0 before the comparator rises must not shorten the charge phase
        run_conv(0, 1);
        run_conv(7, 8);          // R4: result 10 needs the carry from digit 0
        run_conv(2, MAX - 2);    // exact full scale, no over-range
        run_conv(1, MAX - 1);    // R8: first over-range case
        run_conv(3, 3 * MAX);    // R8: far past full scale
        run_conv(0, 20);
        run_abort(1'b0);         // R9: abort during the charge phase
        run_conv(1, 30);
        run_abort(1'b1);         // R9: abort during the discharge phase
        run_conv(2, 45);
        for (int t = 0; t < 30; t++) begin
            run_conv(int'($urandom_range(0, 6)), int'($urandom_range(1, MAX + 15)));
        end
        report();
    end
endmodule